// File: doc/BRIEF.md
# DAC Power-Mode Sequencer

This block sits between a host and the digital control pins of a 10-bit parallel-input DAC. The host asks for one of three power modes: active, standby or shutdown. The block drives the matching levels on the converter's power-down select, its enable line and its active-low chip select. Each time the converter is woken from standby or from shutdown, a settling timer runs. A ready flag rises only when the analog outputs have had time to settle. The timer length is derived from the system clock frequency and a settling time given in microseconds (50 µs by default).

Once ready, the host's sample-valid strobes load samples onto the 10-bit data bus. The converter registers data in two stages: its input latch captures the bus on a rising edge, and its output register takes the latch content on the next rising edge. The block keeps a digital copy of both stages, so it can report the code currently held by the converter's output register. While the converter is not ready, strobes are dropped and the bus is held at zero.

Top module: `dac_pwr_seq`

## Requirements
- R1: During and after synchronous reset, shutdown is selected: `dac_pd`=1, `dac_en`=0, `dac_cs_n`=1, `ready`=0, `dac_data`=0, `out_code`=0.
- R2: A request with `req_mode`=2'b10 (shutdown) gives `dac_pd`=1, `dac_en`=0, `dac_cs_n`=1 and `ready`=0 after the next clock edge.
- R3: A request with `req_mode`=2'b01 (standby) gives `dac_pd`=0, `dac_en`=0, `dac_cs_n`=1 and `ready`=0 after the next clock edge.
- R4: A request with `req_mode`=2'b00 (active) gives `dac_pd`=0, `dac_en`=1, `dac_cs_n`=0 after the next clock edge.
- R5: An active request made while not ready raises `ready` exactly WAKE+1 clock edges after the request edge, counting that edge. WAKE = (CLK_HZ/1,000,000)·SETTLE_US, and is 2000 by default.
- R6: A request made during the settling wait restarts the sequence from the requested mode. An active request restarts the full wait. A standby or shutdown request cancels the wake-up.
- R7: An active request while already ready has no effect: `ready` stays 1.
- R8: `req_mode`=2'b11 is reserved, and a request carrying it changes neither the pins nor `ready`.
- R9: While `ready`=0, `smp_valid` is ignored and `dac_data` is 0 after the next edge.
- R10: While `ready`=1, `smp_valid`=1 puts `smp_data` on `dac_data` after the next edge. With `smp_valid`=0, `dac_data` holds its value.
- R11: `out_code` equals the value `dac_data` had two clock edges earlier: one edge for the input latch and one for the output register.
- R12: Whenever `ready`=1, the pins show the active encoding (`dac_pd`=0, `dac_en`=1, `dac_cs_n`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the converter clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 2 | Requested mode: 00 active, 01 standby, 10 shutdown, 11 reserved |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DW (10) | Sample code |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_pd | output | 1 | Converter power-down select |
| dac_en | output | 1 | Converter enable |
| dac_data | output | DW (10) | Converter parallel data bus |
| ready | output | 1 | Outputs settled, samples accepted |
| out_code | output | DW (10) | Code held in the converter's output register |

## Verification
The sample path is driven with a stimulus table that mixes strobed and idle cycles and includes the all-zeros and all-ones codes. A strobed cycle shows that the bus loads. An idle cycle shows that it holds. The two-cycle offset between bus and reported code is checked against a running history, which would expose a pipeline one stage short or one stage long. The power sequence is tried in four patterns: a clean wake from shutdown, a wake from standby, a wake restarted part-way through, and a wake cancelled by shutdown. Together these separate a timer that restarts from one that merely continues, and a cancel from a request that is ignored. Redundant and reserved requests made while ready check that nothing disturbs a settled converter.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [1:0] {
        PM_ACTIVE   = 2'b00,
        PM_STANDBY  = 2'b01,
        PM_SHUTDOWN = 2'b10,
        PM_RSVD     = 2'b11
    } pmode_e;

    typedef struct packed {
        logic pd;
        logic en;
        logic cs_n;
    } pins_t;

    // Pin levels for each power mode
    function automatic pins_t pins_of(pmode_e m);
        pins_t p;
        p.pd   = (m == PM_SHUTDOWN);
        p.en   = (m == PM_ACTIVE);
        p.cs_n = (m != PM_ACTIVE);
        return p;
    endfunction

    // Settling wait in clock cycles, at least one
    function automatic int unsigned wake_cycles(int unsigned hz, int unsigned us);
        int unsigned c;
        c = (hz / 1_000_000) * us;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/dps_wake_timer.sv
module dps_wake_timer #(
    parameter int unsigned WAKE = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    localparam int unsigned CW = $clog2(WAKE + 1);
    localparam logic [CW-1:0] LOADV = CW'(WAKE);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= LOADV;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/dps_mode_ctl.sv
module dps_mode_ctl
    import dps_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic [1:0] req_mode,
    input  logic       timer_done,
    output logic       start,
    output logic       is_active,
    output pins_t      pins
);
    pmode_e mode_q;
    pmode_e req_e;
    logic   req_ok;

    assign req_e     = pmode_e'(req_mode);
    assign req_ok    = req_valid && (req_e != PM_RSVD);
    assign is_active = (mode_q == PM_ACTIVE);
    // Start a wake-up unless the converter is already settled and active
    assign start     = req_ok && (req_e == PM_ACTIVE) && !(is_active && timer_done);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= PM_SHUTDOWN;
        else if (req_ok)
            mode_q <= req_e;
    end

    assign pins = pins_of(mode_q);
endmodule

// File: rtl/dps_sample_pipe.sv
module dps_sample_pipe #(
    parameter int unsigned DW     = 10,
    parameter int unsigned STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ready,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    output logic [DW-1:0] bus,
    output logic [DW-1:0] code
);
    logic [DW-1:0] stg [STAGES+1];

    always_ff @(posedge clk) begin
        if (rst || !ready)
            bus <= '0;
        else if (smp_valid)
            bus <= smp_data;
    end

    assign stg[0] = bus;

    // Copy of the converter's input latch and output register
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stg[i+1] <= '0;
            else
                stg[i+1] <= stg[i];
        end
    end

    assign code = stg[STAGES];
endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
    import dps_pkg::*;
#(
    parameter int unsigned DW        = 10,
    parameter int unsigned CLK_HZ    = 40_000_000,
    parameter int unsigned SETTLE_US = 50
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_mode,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    output logic          dac_cs_n,
    output logic          dac_pd,
    output logic          dac_en,
    output logic [DW-1:0] dac_data,
    output logic          ready,
    output logic [DW-1:0] out_code
);
    localparam int unsigned WAKE_CYC   = wake_cycles(CLK_HZ, SETTLE_US);
    localparam int unsigned PIPE_DEPTH = 2;

    logic  start;
    logic  is_active;
    logic  timer_done;
    pins_t pins;

    dps_mode_ctl u_mode (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .timer_done (timer_done),
        .start      (start),
        .is_active  (is_active),
        .pins       (pins)
    );

    dps_wake_timer #(.WAKE(WAKE_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (start),
        .done (timer_done)
    );

    assign ready = is_active && timer_done;

    dps_sample_pipe #(.DW(DW), .STAGES(PIPE_DEPTH)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .ready     (ready),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .bus       (dac_data),
        .code      (out_code)
    );

    assign dac_cs_n = pins.cs_n;
    assign dac_pd   = pins.pd;
    assign dac_en   = pins.en;
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
    parameter int unsigned DW   = 10,
    parameter int unsigned WAKE = 2000
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic [1:0]    req_mode,
    input logic          dac_cs_n,
    input logic          dac_pd,
    input logic          dac_en,
    input logic [DW-1:0] dac_data,
    input logic          ready,
    input logic [DW-1:0] out_code
);
    localparam int unsigned CW = $clog2(WAKE + 3);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};
    localparam logic [CW-1:0] EXPV = CW'(WAKE + 1);

    logic [1:0]    age;
    logic [CW-1:0] since;

    always_ff @(posedge clk) begin
        if (rst)
            age <= '0;
        else if (age != 2'd3)
            age <= age + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            since <= '0;
        else if (req_valid && req_mode == 2'b00 && !ready)
            since <= CW'(1);
        else if (since != '0 && since != CMAX)
            since <= since + 1'b1;
    end

    p_ready_pins_r12: assert property (@(posedge clk) disable iff (rst)
        ready |-> (dac_en && !dac_pd && !dac_cs_n));

    p_shutdown_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 2'b10) |=> (dac_pd && !dac_en && dac_cs_n && !ready));

    p_standby_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 2'b01) |=> (!dac_pd && !dac_en && dac_cs_n && !ready));

    p_active_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 2'b00) |=> (!dac_pd && dac_en && !dac_cs_n));

    p_idle_bus_r9: assert property (@(posedge clk) disable iff (rst)
        !ready |=> (dac_data == '0));

    p_pipe_r11: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3) |-> (out_code == $past(dac_data, 2)));

    p_wake_len_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (since == EXPV));

    p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 2'b11) |=> $stable({dac_pd, dac_en, dac_cs_n}));
endmodule

bind dac_pwr_seq dps_checker #(.DW(DW), .WAKE(WAKE_CYC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_mode (req_mode),
    .dac_cs_n (dac_cs_n),
    .dac_pd   (dac_pd),
    .dac_en   (dac_en),
    .dac_data (dac_data),
    .ready    (ready),
    .out_code (out_code)
);

// File: tb/dac_pwr_seq_bench.sv
module dac_pwr_seq_bench;
    localparam int DW = 10;
    localparam int W  = 8;   // (1 MHz / 1 MHz) * 8 us

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_mode = 2'b00;
    logic          smp_valid = 1'b0;
    logic [DW-1:0] smp_data = '0;
    logic          dac_cs_n, dac_pd, dac_en, ready;
    logic [DW-1:0] dac_data, out_code;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dac_pwr_seq #(.DW(DW), .CLK_HZ(1_000_000), .SETTLE_US(8)) u_dac_pwr_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .smp_valid(smp_valid), .smp_data(smp_data), .dac_cs_n(dac_cs_n),
        .dac_pd(dac_pd), .dac_en(dac_en), .dac_data(dac_data),
        .ready(ready), .out_code(out_code)
    );

    // {valid, data}
    localparam logic [DW:0] VEC [8] = '{
        {1'b1, 10'h155}, {1'b0, 10'h3AA}, {1'b1, 10'h3FF}, {1'b1, 10'h000},
        {1'b0, 10'h0F0}, {1'b1, 10'h201}, {1'b1, 10'h07E}, {1'b0, 10'h111}
    };

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pins(input string tag, input int pd, input int en, input int csn);
        chk({tag, " pd"}, int'(dac_pd), pd);
        chk({tag, " en"}, int'(dac_en), en);
        chk({tag, " cs_n"}, int'(dac_cs_n), csn);
    endtask

    task automatic request(input logic [1:0] m);
        req_valid = 1'b1;
        req_mode  = m;
        step();
        req_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=5000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] b1, b2, bn;
        repeat (3) step();
        pins("R1 in reset", 1, 0, 1);
        chk("R1 ready", int'(ready), 0);
        rst = 1'b0;
        step();
        pins("R1 after reset", 1, 0, 1);
        chk("R1 data", int'(dac_data), 0);
        chk("R1 code", int'(out_code), 0);

        // Wake from shutdown, strobes ignored while settling
        request(2'b00);
        pins("R4 active", 0, 1, 0);
        chk("R5 ready s1", int'(ready), 0);
        smp_valid = 1'b1; smp_data = 10'h3FF;
        for (int s = 2; s <= W; s++) step();
        chk("R5 ready at W", int'(ready), 0);
        chk("R9 bus zero while waking", int'(dac_data), 0);
        smp_valid = 1'b0;
        step();
        chk("R5 ready at W+1", int'(ready), 1);
        chk("R12 pins when ready", int'(dac_pd) + 2*int'(dac_en) + 4*int'(dac_cs_n), 2);
        step(); step();

        // Table walk over the sample path
        b1 = '0; b2 = '0;
        for (int i = 0; i < 8; i++) begin
            smp_valid = VEC[i][DW];
            smp_data  = VEC[i][DW-1:0];
            step();
            bn = VEC[i][DW] ? VEC[i][DW-1:0] : b1;
            chk($sformatf("R10 bus v%0d", i), int'(dac_data), int'(bn));
            chk($sformatf("R11 code v%0d", i), int'(out_code), int'(b2));
            b2 = b1; b1 = bn;
        end
        smp_valid = 1'b0;

        // Redundant and reserved requests while ready
        request(2'b00);
        chk("R7 ready kept", int'(ready), 1);
        request(2'b11);
        chk("R8 ready kept", int'(ready), 1);
        pins("R8 pins kept", 0, 1, 0);
        chk("R8 bus kept", int'(dac_data), int'(b1));

        // Standby, then restarted wake
        request(2'b01);
        pins("R3 standby", 0, 0, 1);
        chk("R3 ready", int'(ready), 0);
        smp_valid = 1'b1; smp_data = 10'h2AA;
        step();
        chk("R9 bus cleared in standby", int'(dac_data), 0);
        smp_valid = 1'b0;
        request(2'b00);
        step(); step();
        request(2'b00);
        for (int s = 2; s <= W - 2; s++) step();
        chk("R6 no ready at old deadline", int'(ready), 0);
        step(); step();
        chk("R6 ready low at W", int'(ready), 0);
        step();
        chk("R6 ready after restart", int'(ready), 1);

        // Wake cancelled by shutdown
        request(2'b10);
        pins("R2 shutdown", 1, 0, 1);
        chk("R2 ready", int'(ready), 0);
        request(2'b00);
        step();
        request(2'b10);
        for (int s = 0; s < W + 4; s++) step();
        chk("R6 cancelled stays low", int'(ready), 0);
        pins("R6 cancelled pins", 1, 0, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule